// File: doc/BRIEF.md
# Parallel 8080-Style LCD Bus Engine

This block runs single transactions on an 8080-style parallel bus to a graphic display controller. An upstream queue offers one request at a time through a valid/ready handshake. Each request is a read or a write, carries a one-bit data/command flag, and, for writes, carries a data word. The engine drives the chip select, write strobe, read strobe, data/command line, output data bus and pad output-enable. On reads it captures the controller's input bus and returns the value with a one-cycle valid pulse.

A write always takes three cycles, with a write strobe one clock wide. A read holds chip select and read strobe low for a programmable number of clocks, samples the input bus one clock before the strobes rise, and then waits a programmable number of high clocks before it ends. The bus width is a parameter of 8 or 16 bits and defaults to 16. The suggested pulse settings for a typical controller are 10 low and 10 high. A new request is accepted in the final cycle of the current transaction, so transactions can run back to back.

The controller is a state machine with states `ST_IDLE`, `ST_WR_SETUP`, `ST_WR_STROBE`, `ST_WR_HOLD`, `ST_RD_LOW` and `ST_RD_HIGH`. Its transitions are:

- idle to setup, or idle to low, on acceptance.
- setup to strobe to hold, on every clock.
- low to high, when the low timer is spent.
- hold to idle, or high to idle, when no request is taken.
- hold or spent-high directly to setup or low, when a request is taken in the final cycle.

Top module: `lcd_bus_engine`

## Requirements
- R1: During and after synchronous reset `rst`, lcd_cs_n, lcd_wr_n and lcd_rd_n are 1, lcd_oe is 0, rd_valid is 0 and req_ready is 1. The bus returns to this state in the cycle after any transaction ends without a new request.
- R2: A write accepted at clock edge k holds lcd_cs_n low and lcd_oe high for the three cycles after k, with lcd_dc and lcd_dout equal to the request. lcd_wr_n is low only in the second of those cycles.
- R3: A read holds lcd_cs_n and lcd_rd_n low together for exactly the effective low count, starting the cycle after acceptance. During that time lcd_oe stays 0 and lcd_dc equals the request flag (1 = data, 0 = command).
- R4: rd_valid is high for exactly one cycle per read: the final low cycle of that read. rd_data then holds the value lcd_din had in the cycle before it.
- R5: After the low phase, lcd_cs_n and lcd_rd_n are high for exactly the effective high count, and req_ready is high only in the last of those cycles.
- R6: A low setting below 2 is treated as 2, and a high setting of 0 is treated as 1.
- R7: The pulse settings are taken at acceptance. Changing cfg_rd_low or cfg_rd_high during a read does not change that read's timing.
- R8: req_ready is high when idle and in the final cycle of a transaction. A request taken in that final cycle starts its first bus cycle on the next clock, with no idle cycle in between.
- R9: With an 8-bit bus, rd_data[15:8] is zero and rd_data[7:0] is the captured byte.
- R10: rd_valid never pulses during a write, and lcd_wr_n and lcd_rd_n are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rd_low | input | CNT_W | Read strobe low width in clocks |
| cfg_rd_high | input | CNT_W | Read high width in clocks |
| req_valid | input | 1 | Request offered |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_dc | input | 1 | 1 = data, 0 = command |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Request taken when high with req_valid |
| rd_valid | output | 1 | One-cycle read result strobe |
| rd_data | output | 16 | Captured read value, zero-extended |
| lcd_dc | output | 1 | Data/command line |
| lcd_cs_n | output | 1 | Chip select, active low |
| lcd_wr_n | output | 1 | Write strobe, active low |
| lcd_rd_n | output | 1 | Read strobe, active low |
| lcd_oe | output | 1 | Output enable for the data pads |
| lcd_dout | output | DATA_W | Output data bus |
| lcd_din | input | DATA_W | Input data bus |

## Verification
The bus pins are decoded directly from the state register, so a wrong state shows on lcd_cs_n, lcd_wr_n, lcd_rd_n or lcd_oe in the same cycle it occurs. A miscounted pulse timer shows up within that read as a low or high phase of the wrong length, or as a misplaced rd_valid and req_ready. A wrong capture point shows as rd_data equal to the input pattern of a neighbouring cycle. The bench detects this because it drives lcd_din with a value that changes every clock.

// File: rtl/lcd_bus_pkg.sv
package lcd_bus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_SETUP,
        ST_WR_STROBE,
        ST_WR_HOLD,
        ST_RD_LOW,
        ST_RD_HIGH
    } bus_state_t;

    // Width of the returned read word, independent of the bus width
    localparam int RDATA_W = 16;

    // Smallest usable pulse counts: the low phase needs one cycle to sample
    // and one more before the strobes rise
    localparam int RD_LOW_MIN  = 2;
    localparam int RD_HIGH_MIN = 1;

endpackage

// File: rtl/lcd_pulse_timer.sv
module lcd_pulse_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             cnt_zero,
    output logic             cnt_one
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign cnt_zero = (cnt_q == '0);
    assign cnt_one  = (cnt_q == CNT_W'(1));

    // A spent counter stays spent until it is reloaded
    AST_TIMER_HOLD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cnt_zero && !load) |=> cnt_zero); // R5

endmodule

// File: rtl/lcd_read_capture.sv
module lcd_read_capture #(
    parameter int DATA_W = 16,
    parameter int OUT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    output logic              rd_valid,
    output logic [OUT_W-1:0]  rd_data
);

    logic [DATA_W-1:0] cap_q;
    logic              vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= capture;
            if (capture) begin
                cap_q <= din;
            end
        end
    end

    generate
        if (DATA_W < OUT_W) begin : g_zext
            assign rd_data = {{(OUT_W-DATA_W){1'b0}}, cap_q};
        end else begin : g_full
            assign rd_data = cap_q[OUT_W-1:0];
        end
    endgenerate

    assign rd_valid = vld_q;

    // One capture per read: the strobe never lasts two cycles
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        vld_q |=> !vld_q); // R4

endmodule

// File: rtl/lcd_bus_fsm.sv
module lcd_bus_fsm
    import lcd_bus_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  logic req_rd,
    input  logic low_zero,
    input  logic low_one,
    input  logic high_zero,
    output logic ready,
    output logic accept,
    output logic load_low,
    output logic load_high,
    output logic run_low,
    output logic run_high,
    output logic capture,
    output logic cs_n,
    output logic wr_n,
    output logic rd_n,
    output logic oe
);

    bus_state_t state_q;
    bus_state_t state_d;

    // Ready when idle or in the final cycle of a transaction
    always_comb begin
        ready = 1'b0;
        unique case (state_q)
            ST_IDLE:      ready = 1'b1;
            ST_WR_HOLD:   ready = 1'b1;
            ST_RD_HIGH:   ready = high_zero;
            default:      ready = 1'b0;
        endcase
    end

    assign accept = req_valid && ready;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (accept) begin
            state_d = req_rd ? ST_RD_LOW : ST_WR_SETUP;
        end else begin
            unique case (state_q)
                ST_IDLE:      state_d = ST_IDLE;
                ST_WR_SETUP:  state_d = ST_WR_STROBE;
                ST_WR_STROBE: state_d = ST_WR_HOLD;
                ST_WR_HOLD:   state_d = ST_IDLE;
                ST_RD_LOW:    state_d = low_zero ? ST_RD_HIGH : ST_RD_LOW;
                ST_RD_HIGH:   state_d = high_zero ? ST_IDLE : ST_RD_HIGH;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs decoded from the current state
    always_comb begin
        cs_n      = 1'b1;
        wr_n      = 1'b1;
        rd_n      = 1'b1;
        oe        = 1'b0;
        run_low   = 1'b0;
        run_high  = 1'b0;
        capture   = 1'b0;
        load_high = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_WR_SETUP: begin
                cs_n = 1'b0;
                oe   = 1'b1;
            end
            ST_WR_STROBE: begin
                cs_n = 1'b0;
                oe   = 1'b1;
                wr_n = 1'b0;
            end
            ST_WR_HOLD: begin
                cs_n = 1'b0;
                oe   = 1'b1;
            end
            ST_RD_LOW: begin
                cs_n      = 1'b0;
                rd_n      = 1'b0;
                run_low   = 1'b1;
                capture   = low_one;
                load_high = low_zero;
            end
            ST_RD_HIGH: begin
                run_high = 1'b1;
            end
            default: begin
            end
        endcase
    end

    assign load_low = accept && req_rd;

    AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        !wr_n |=> wr_n); // R2
    AST_WR_SETUP_BEFORE: assert property (@(posedge clk) disable iff (rst)
        $fell(wr_n) |-> (!cs_n && $past(!cs_n) && $past(oe))); // R2
    AST_WR_HOLD_AFTER: assert property (@(posedge clk) disable iff (rst)
        !wr_n |=> (!cs_n && oe)); // R2
    AST_RD_PADS_INPUT: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> (!oe && !cs_n)); // R3
    AST_RD_MIN_LOW: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_n) |=> !rd_n); // R6
    AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (rst)
        !(!wr_n && !rd_n)); // R10

endmodule

// File: rtl/lcd_bus_engine.sv
module lcd_bus_engine
    import lcd_bus_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [CNT_W-1:0]   cfg_rd_low,
    input  logic [CNT_W-1:0]   cfg_rd_high,
    input  logic               req_valid,
    input  logic               req_rd,
    input  logic               req_dc,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               req_ready,
    output logic               rd_valid,
    output logic [RDATA_W-1:0] rd_data,
    output logic               lcd_dc,
    output logic               lcd_cs_n,
    output logic               lcd_wr_n,
    output logic               lcd_rd_n,
    output logic               lcd_oe,
    output logic [DATA_W-1:0]  lcd_dout,
    input  logic [DATA_W-1:0]  lcd_din
);

    localparam logic [CNT_W-1:0] LOW_MIN  = CNT_W'(RD_LOW_MIN);
    localparam logic [CNT_W-1:0] HIGH_MIN = CNT_W'(RD_HIGH_MIN);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    logic              accept;
    logic              load_low;
    logic              load_high;
    logic              run_low;
    logic              run_high;
    logic              capture;
    logic              low_zero;
    logic              low_one;
    logic              high_zero;
    logic              high_one;
    logic [CNT_W-1:0]  low_eff;
    logic [CNT_W-1:0]  high_eff;
    logic [CNT_W-1:0]  high_q;
    logic              dc_q;
    logic [DATA_W-1:0] dout_q;

    // Settings below the minimum are raised to it
    assign low_eff  = (cfg_rd_low  < LOW_MIN)  ? LOW_MIN  : cfg_rd_low;
    assign high_eff = (cfg_rd_high < HIGH_MIN) ? HIGH_MIN : cfg_rd_high;

    // Request fields and the high width are taken at acceptance
    always_ff @(posedge clk) begin
        if (rst) begin
            dc_q   <= 1'b0;
            dout_q <= '0;
            high_q <= '0;
        end else if (accept) begin
            dc_q   <= req_dc;
            high_q <= high_eff - ONE;
            if (!req_rd) begin
                dout_q <= req_wdata;
            end
        end
    end

    lcd_bus_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_rd    (req_rd),
        .low_zero  (low_zero),
        .low_one   (low_one),
        .high_zero (high_zero),
        .ready     (req_ready),
        .accept    (accept),
        .load_low  (load_low),
        .load_high (load_high),
        .run_low   (run_low),
        .run_high  (run_high),
        .capture   (capture),
        .cs_n      (lcd_cs_n),
        .wr_n      (lcd_wr_n),
        .rd_n      (lcd_rd_n),
        .oe        (lcd_oe)
    );

    lcd_pulse_timer #(.CNT_W(CNT_W)) u_low_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (load_low),
        .load_val (low_eff - ONE),
        .run      (run_low),
        .cnt_zero (low_zero),
        .cnt_one  (low_one)
    );

    lcd_pulse_timer #(.CNT_W(CNT_W)) u_high_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (load_high),
        .load_val (high_q),
        .run      (run_high),
        .cnt_zero (high_zero),
        .cnt_one  (high_one)
    );

    lcd_read_capture #(.DATA_W(DATA_W), .OUT_W(RDATA_W)) u_capture (
        .clk      (clk),
        .rst      (rst),
        .capture  (capture),
        .din      (lcd_din),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    assign lcd_dc   = dc_q;
    assign lcd_dout = dout_q;

    // The strobes rise in the cycle right after the result strobe
    AST_VALID_THEN_RISE: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> (lcd_rd_n && lcd_cs_n)); // R4
    // A result only ever appears while the read strobe is low
    AST_VALID_IN_READ: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (!lcd_rd_n && lcd_wr_n)); // R10
    // The high timer is one step from spent only while counting down
    AST_HIGH_ONE_RUN: assert property (@(posedge clk) disable iff (rst)
        (high_one && run_high) |=> (high_zero && lcd_cs_n)); // R5

endmodule

// File: tb/lcd_bus_engine_tb.sv
`timescale 1ns/1ps
module lcd_bus_engine_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  cfg_rd_low  = 8'd10;
    logic [7:0]  cfg_rd_high = 8'd10;
    logic        req_valid = 1'b0;
    logic        req_rd    = 1'b0;
    logic        req_dc    = 1'b0;
    logic [15:0] req_wdata = 16'h0;
    int          cyc = 0;
    int          tests = 0;
    int          fails = 0;

    logic        req_ready, rd_valid, lcd_dc, lcd_cs_n, lcd_wr_n, lcd_rd_n, lcd_oe;
    logic [15:0] rd_data, lcd_dout, lcd_din;
    logic        r8_ready, r8_valid, r8_dc, r8_cs_n, r8_wr_n, r8_rd_n, r8_oe;
    logic [15:0] r8_data;
    logic [7:0]  r8_dout;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [15:0] pat(input int c);
        return 16'hA5C3 ^ 16'(c * 257);
    endfunction

    assign lcd_din = pat(cyc);

    lcd_bus_engine u_dut (
        .clk(clk), .rst(rst), .cfg_rd_low(cfg_rd_low), .cfg_rd_high(cfg_rd_high),
        .req_valid(req_valid), .req_rd(req_rd), .req_dc(req_dc), .req_wdata(req_wdata),
        .req_ready(req_ready), .rd_valid(rd_valid), .rd_data(rd_data),
        .lcd_dc(lcd_dc), .lcd_cs_n(lcd_cs_n), .lcd_wr_n(lcd_wr_n), .lcd_rd_n(lcd_rd_n),
        .lcd_oe(lcd_oe), .lcd_dout(lcd_dout), .lcd_din(lcd_din)
    );

    lcd_bus_engine #(.DATA_W(8)) u_dut8 (
        .clk(clk), .rst(rst), .cfg_rd_low(cfg_rd_low), .cfg_rd_high(cfg_rd_high),
        .req_valid(req_valid), .req_rd(req_rd), .req_dc(req_dc), .req_wdata(req_wdata[7:0]),
        .req_ready(r8_ready), .rd_valid(r8_valid), .rd_data(r8_data),
        .lcd_dc(r8_dc), .lcd_cs_n(r8_cs_n), .lcd_wr_n(r8_wr_n), .lcd_rd_n(r8_rd_n),
        .lcd_oe(r8_oe), .lcd_dout(r8_dout), .lcd_din(lcd_din[7:0])
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Pin word: {cs_n, wr_n, rd_n, oe}
    function automatic logic [3:0] pins();
        return {lcd_cs_n, lcd_wr_n, lcd_rd_n, lcd_oe};
    endfunction

    task automatic check_idle(input string req);
        chk(req, "idle pins", {28'h0, pins()}, 32'hE);
        chk(req, "idle ready/valid", {30'h0, req_ready, rd_valid}, 32'h2);
    endtask

    // Offer a request at a falling edge, let it be taken, return in cycle 1
    task automatic start_req(input logic rd, input logic dc, input logic [15:0] data);
        @(negedge clk);
        req_valid = 1'b1; req_rd = rd; req_dc = dc; req_wdata = data;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic test_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check_idle("R1");
        rst = 1'b0;
        @(negedge clk);
        check_idle("R1");
    endtask

    task automatic test_write(input logic dc, input logic [15:0] data);
        start_req(1'b0, dc, data);
        chk("R2", "c1 pins", {28'h0, pins()}, 32'h7);
        chk("R2", "c1 dc", {31'h0, lcd_dc}, {31'h0, dc});
        chk("R2", "c1 dout", {16'h0, lcd_dout}, {16'h0, data});
        chk("R8", "c1 ready", {31'h0, req_ready}, 32'h0);
        @(negedge clk);
        chk("R2", "c2 pins", {28'h0, pins()}, 32'h3);
        chk("R10", "c2 valid", {31'h0, rd_valid}, 32'h0);
        @(negedge clk);
        chk("R2", "c3 pins", {28'h0, pins()}, 32'h7);
        chk("R2", "c3 dout", {16'h0, lcd_dout}, {16'h0, data});
        chk("R8", "c3 ready", {31'h0, req_ready}, 32'h1);
        @(negedge clk);
        check_idle("R1");
    endtask

    task automatic test_read(input logic dc, input logic [7:0] lo, input logic [7:0] hi,
                             input int exp_lo, input int exp_hi, input bit change_cfg);
        int nvalid = 0;
        @(negedge clk);
        cfg_rd_low = lo; cfg_rd_high = hi;
        start_req(1'b1, dc, 16'h0);
        for (int i = 0; i < exp_lo; i++) begin
            if (i == 0 && change_cfg) begin
                cfg_rd_low = 8'd40; cfg_rd_high = 8'd30;   // R7: must not matter
            end
            chk("R3", "low pins", {28'h0, pins()}, 32'h4);
            chk("R3", "low dc", {31'h0, lcd_dc}, {31'h0, dc});
            chk("R4", "valid position", {31'h0, rd_valid}, {31'h0, (i == exp_lo - 1)});
            if (rd_valid) begin
                nvalid++;
                chk("R4", "rd_data", {16'h0, rd_data}, {16'h0, pat(cyc - 1)});
                chk("R9", "8-bit rd_data", {16'h0, r8_data}, {24'h0, pat(cyc - 1)[7:0]});
                chk("R9", "8-bit valid", {31'h0, r8_valid}, 32'h1);
            end
            @(negedge clk);
        end
        for (int j = 0; j < exp_hi; j++) begin
            chk("R5", "high pins", {28'h0, pins()}, 32'hE);
            chk("R5", "high ready", {31'h0, req_ready}, {31'h0, (j == exp_hi - 1)});
            if (change_cfg) chk("R7", "high ready", {31'h0, req_ready}, {31'h0, (j == exp_hi - 1)});
            @(negedge clk);
        end
        chk("R4", "valid count", nvalid, 1);
        check_idle("R1");
        cfg_rd_low = 8'd10; cfg_rd_high = 8'd10;
    endtask

    task automatic test_back_to_back();
        start_req(1'b0, 1'b1, 16'h1234);
        @(negedge clk);
        @(negedge clk);
        chk("R8", "write final ready", {31'h0, req_ready}, 32'h1);
        cfg_rd_low = 8'd2; cfg_rd_high = 8'd1;
        req_valid = 1'b1; req_rd = 1'b1; req_dc = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R8", "write->read no gap", {28'h0, pins()}, 32'h4);
        chk("R3", "read dc cmd", {31'h0, lcd_dc}, 32'h0);
        @(negedge clk);
        chk("R4", "b2b valid", {31'h0, rd_valid}, 32'h1);
        chk("R4", "b2b data", {16'h0, rd_data}, {16'h0, pat(cyc - 1)});
        @(negedge clk);
        chk("R8", "read final ready", {31'h0, req_ready}, 32'h1);
        req_valid = 1'b1; req_rd = 1'b0; req_dc = 1'b1; req_wdata = 16'hBEEF;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R8", "read->write start", {28'h0, pins()}, 32'h7);
        chk("R2", "b2b dout", {16'h0, lcd_dout}, 32'hBEEF);
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        check_idle("R1");
        cfg_rd_low = 8'd10; cfg_rd_high = 8'd10;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        test_reset();
        test_write(1'b1, 16'hA55A);
        test_write(1'b0, 16'h00FF);
        test_read(1'b1, 8'd10, 8'd10, 10, 10, 1'b0);
        test_read(1'b0, 8'd2, 8'd1, 2, 1, 1'b0);
        test_read(1'b1, 8'd1, 8'd0, 2, 1, 1'b0);     // R6 clamp
        test_read(1'b1, 8'd0, 8'd3, 2, 3, 1'b0);     // R6 clamp low only
        test_read(1'b1, 8'd5, 8'd4, 5, 4, 1'b1);     // R7 mid-read change
        test_read(1'b0, 8'd255, 8'd2, 255, 2, 1'b0);
        test_back_to_back();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule